// File: doc/BRIEF.md
# Bit-Slice Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit assembled from a row of identical one-bit cells. Every cell is a full adder, and its three inputs pass through gating first. One control bit can complement the A operand. A second control bit can force the B operand to zero. The mode bit can force the incoming carry to zero. With these three gates, four bitwise logic functions and eight arithmetic functions all come out of the same cell.

In arithmetic mode the carry ripples from bit 0 toward the most significant bit, and the final carry appears on `carry_out`. In logic mode each bit depends only on its own operand bits. The external carry input has no effect in that mode, and `carry_out` is held at 0. The operand width is a parameter with a default of 4 bits.

Top module: `slice_alu`

## Requirements
- R1: With `mode`=0 and `sel`=2'b00, `f` equals `a`.
- R2: With `mode`=0 and `sel`=2'b01, `f` equals the bitwise complement of `a`.
- R3: With `mode`=0, `sel`=2'b10 gives `f` = `a` XOR `b`, and `sel`=2'b11 gives `f` = `a` XNOR `b`.
- R4: With `mode`=0, `carry_out` is 0 and `carry_in` has no effect on `f` or `carry_out`.
- R5: With `mode`=1 and `carry_in`=0, `sel`=2'b00 gives `f`=`a` and `sel`=2'b01 gives `f`=~`a`, both with `carry_out`=0.
- R6: With `mode`=1 and `sel`=2'b10, {`carry_out`,`f`} equals `a` + `b` + `carry_in` as a WIDTH+1 bit unsigned sum.
- R7: With `mode`=1 and `sel`=2'b11, {`carry_out`,`f`} equals ~`a` + `b` + `carry_in`. With `carry_in`=1 this makes `f` = `b` − `a` modulo 2^WIDTH.
- R8: With `mode`=1 and `carry_in`=1, `sel`=2'b00 gives {`carry_out`,`f`} = `a`+1, and `sel`=2'b01 gives {`carry_out`,`f`} = ~`a`+1. The second case yields the two's complement of `a` in `f`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand; complemented when `sel[0]`=1 |
| b | input | WIDTH | Second operand; used only when `sel[1]`=1 |
| mode | input | 1 | 0 = bitwise logic, 1 = arithmetic with carry chain |
| sel | input | 2 | Bit 1 enables `b`, bit 0 complements `a` |
| carry_in | input | 1 | Carry into bit 0; used only in arithmetic mode |
| f | output | WIDTH | Result |
| carry_out | output | 1 | Carry out of the top bit; 0 in logic mode |

## Verification
The assertions are immediate checks on settled combinational values. They assume all inputs are known and held steady while the carry chain resolves. The stimulus therefore changes the inputs only once per clock cycle, and every input is always driven to a defined 0 or 1. For the default width, the bench walks through every combination of operands, mode, select and carry input. Each result is compared against an arithmetic model of the requirements, so both carry values are exercised in logic mode as well as in arithmetic mode.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

  typedef struct packed {
    logic arith;
    logic use_b;
    logic inv_a;
  } slice_ctrl_t;

  function automatic slice_ctrl_t decode_ctrl(input logic mode, input logic [1:0] sel);
    slice_ctrl_t c;
    c.arith = mode;
    c.use_b = sel[1];
    c.inv_a = sel[0];
    return c;
  endfunction

endpackage

// File: rtl/slice_alu_gate.sv
module slice_alu_gate
  import slice_alu_pkg::*;
(
  input  slice_ctrl_t ctrl,
  input  logic        a_bit,
  input  logic        b_bit,
  input  logic        c_bit,
  output logic        a_g,
  output logic        b_g,
  output logic        c_g
);

  always_comb begin
    a_g = a_bit ^ ctrl.inv_a;
    b_g = b_bit & ctrl.use_b;
    c_g = c_bit & ctrl.arith;
  end

  always_comb begin
    if (!ctrl.arith) begin
      assert_gate_carry_R4: assert (c_g == 1'b0)
        else $error("carry reached a logic-mode cell");
    end
  end

endmodule

// File: rtl/slice_alu_cell.sv
module slice_alu_cell (
  input  logic a_g,
  input  logic b_g,
  input  logic c_g,
  output logic f_bit,
  output logic c_out
);

  logic half;

  always_comb begin
    half  = a_g ^ b_g;
    f_bit = half ^ c_g;
    c_out = (a_g & b_g) | (c_g & half);
  end

  always_comb begin
    assert_cell_sum_R6: assert ({c_out, f_bit} == (2'(a_g) + 2'(b_g) + 2'(c_g)))
      else $error("cell does not add its three inputs");
  end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             mode,
  input  logic [1:0]       sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] f,
  output logic             carry_out
);

  localparam int CHAIN = WIDTH + 1;

  slice_ctrl_t      ctrl;
  logic [CHAIN-1:0] chain;
  logic [WIDTH-1:0] ag, bg, cg;

  assign ctrl     = decode_ctrl(mode, sel);
  assign chain[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    slice_alu_gate u_gate (
      .ctrl  (ctrl),
      .a_bit (a[i]),
      .b_bit (b[i]),
      .c_bit (chain[i]),
      .a_g   (ag[i]),
      .b_g   (bg[i]),
      .c_g   (cg[i])
    );
    slice_alu_cell u_cell (
      .a_g   (ag[i]),
      .b_g   (bg[i]),
      .c_g   (cg[i]),
      .f_bit (f[i]),
      .c_out (chain[i+1])
    );
  end

  assign carry_out = chain[WIDTH] & ctrl.arith;

  always_comb begin
    if (!mode) begin
      assert_logic_nocarry_R4: assert (carry_out == 1'b0)
        else $error("carry out active in logic mode");
      unique case (sel)
        2'b00: assert_pass_R1: assert (f == a) else $error("pass A wrong");
        2'b01: assert_invert_R2: assert ((f | a) == '1 && (f & a) == '0)
                 else $error("invert A wrong");
        2'b10: assert_xor_R3: assert ((f ^ b) == a) else $error("xor wrong");
        default: assert_xnor_R3: assert ((f ^ b) == ~a) else $error("xnor wrong");
      endcase
    end else if (sel == 2'b10) begin
      assert_add_R6: assert ({carry_out, f} == (CHAIN'(a) + CHAIN'(b) + CHAIN'(carry_in)))
        else $error("add wrong");
    end
  end

endmodule

// File: tb/slice_alu_test.sv
module slice_alu_test;

  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a, b, f;
  logic         mode, carry_in, carry_out;
  logic [1:0]   sel;

  int checks;
  int fails;
  bit done;

  slice_alu #(.WIDTH(W)) uut (
    .a(a), .b(b), .mode(mode), .sel(sel), .carry_in(carry_in),
    .f(f), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string req_tag(input logic m, input logic [1:0] s, input logic c);
    if (!m) begin
      if (s == 2'b00) return "R1";
      if (s == 2'b01) return "R2";
      return "R3";
    end
    if (s == 2'b10) return "R6";
    if (s == 2'b11) return "R7";
    return c ? "R8" : "R5";
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (a=%0d b=%0d mode=%0b sel=%0b cin=%0b)",
               tag, what, act, exp, a, b, mode, sel, carry_in);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    a = '0; b = '0; mode = 1'b0; sel = 2'b00; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: all-zero inputs pass zero through, R4: no carry
    check("R1", int'(f), 0, "idle result");
    check("R4", int'(carry_out), 0, "idle carry");

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 2; c++) begin
          for (int x = 0; x < (1 << W); x++) begin
            for (int y = 0; y < (1 << W); y++) begin
              int exp_f, exp_c, opa, opb, sum;
              @(posedge clk);
              a = W'(x); b = W'(y); mode = m[0]; sel = s[1:0]; carry_in = c[0];
              if (m == 0) begin
                case (s)
                  0: exp_f = x;
                  1: exp_f = ((1 << W) - 1) - x;
                  2: exp_f = x ^ y;
                  default: exp_f = ((1 << W) - 1) - (x ^ y);
                endcase
                exp_c = 0;
              end else begin
                opa   = (s % 2 == 1) ? ((1 << W) - 1) - x : x;
                opb   = (s >= 2) ? y : 0;
                sum   = opa + opb + c;
                exp_f = sum % (1 << W);
                exp_c = sum / (1 << W);
              end
              @(negedge clk);
              check(req_tag(m[0], s[1:0], c[0]), int'(f), exp_f, "result");
              check((m == 0) ? "R4" : req_tag(m[0], s[1:0], c[0]),
                    int'(carry_out), exp_c, "carry");
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule